// File: doc/BRIEF.md
# Shape-List Frame Painter

This block colours each pixel of a 640x480 raster. A separate timing generator supplies the current column and row, a blanking flag and a 3-bit frame code. The block turns these into three 4-bit colour channels. No image is stored in memory. Each of eight built-in frames is a short, fixed list of shapes. A shape is either an axis-aligned filled rectangle or a 45-degree diagonal line segment, and each shape has its own colour. The pixel clock is 25 MHz.

Every shape of every frame is tested in parallel against the current pixel. A multiplexer picks the hit flags and colours of the active frame. A priority picker then chooses the colour of the first shape that matches. A pixel that no shape covers is black, and blanking forces black. The frame code comes from an external controller through plain I/O lines. It passes through two synchronising flip-flops and takes effect only when the raster reaches its first pixel, so a frame is never mixed with the next one. The colour output is registered, so the timing generator must delay its sync outputs by one pixel clock to keep them aligned with the colour.

Top module: `frame_painter`

## Requirements
- R1: While `rst` is high, the colour outputs are zero and the active frame returns to 0. The active frame stays 0 after reset until the next frame start.
- R2: When `blank` is high at a clock edge, all three colour channels are zero after that edge, whatever shape covers the pixel.
- R3: The colour for the pixel presented on `pix_x`/`pix_y` appears on the outputs after the next rising clock edge (one cycle of latency).
- R4: A rectangle covers a pixel when x0 <= x <= x1 and y0 <= y <= y1, with both bounds inclusive.
- R5: A diagonal line from (x0,y0) covers the pixels (x0+k, y0+k) for k = 0 .. x1-x0, and no other pixels.
- R6: When several shapes of the active frame cover a pixel, the shape with the lowest list index sets the colour.
- R7: A pixel covered by no shape is background with colour 0 (red=green=blue=0).
- R8: `frame_sel` passes through two flip-flops. The synchronised value becomes the active frame only in a cycle where `pix_x`=0 and `pix_y`=0, and that pixel is already coloured with the new frame. To be adopted at a frame start, a code must be held for at least two rising edges before that cycle. At any other pixel the active frame is unchanged.
- R9: For frame f (0..7) the list, in priority order, is as follows. Index 0: rectangle x 40f..40f+199, y 50..249, colour red (F,0,0). Index 1: rectangle x 300..459, y 200+10f..349+10f, colour green (0,F,0). Index 2: diagonal from (20,20) with x1 = 120+20f, colour white (F,F,F). Index 3: rectangle x 0..639, y 470..479, colour blue (0,0,8+f). Colours are given as (red,green,blue) nibbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 10 | Current pixel column |
| pix_y | input | 10 | Current pixel row |
| blank | input | 1 | High outside the visible area |
| frame_sel | input | 3 | Asynchronous frame code 0..7 |
| red | output | 4 | Registered red channel |
| green | output | 4 | Registered green channel |
| blue | output | 4 | Registered blue channel |

## Verification
Blanking and shape priority can act on the same pixel. Presenting the pixel (50,50) in frame 0 makes the red rectangle and the white diagonal cover it at the same time. This pixel is shown once with `blank` high, where black is expected, and once with `blank` low, where red must win. Frame adoption also coincides with colouring at pixel (0,0). The code is changed right at a frame start, and the bench checks that adoption waits for the two-flop delay. It then checks that a distinguishing pixel afterwards shows the old frame, followed by the new one.

// File: rtl/fp_pkg.sv
package fp_pkg;

  localparam int COORD_W = 10;
  localparam int CH_W    = 4;
  localparam int COLOR_W = 3 * CH_W;

  typedef enum logic {
    SK_RECT = 1'b0,
    SK_DIAG = 1'b1
  } shape_kind_e;

  typedef struct packed {
    shape_kind_e          kind;
    logic [COORD_W-1:0]   x0;
    logic [COORD_W-1:0]   x1;
    logic [COORD_W-1:0]   y0;
    logic [COORD_W-1:0]   y1;
    logic [COLOR_W-1:0]   color;
  } shape_t;

  localparam logic [CH_W-1:0] CH_FULL = {CH_W{1'b1}};
  localparam logic [CH_W-1:0] CH_NONE = '0;

  // Shape list of every frame; empty slot has x0 > x1 so it never hits.
  function automatic shape_t shape_of(input int frame, input int idx);
    shape_t s;
    s       = '0;
    s.kind  = SK_RECT;
    s.x0    = COORD_W'(1);
    s.x1    = COORD_W'(0);
    case (idx)
      0: begin
        s.x0    = COORD_W'(40 * frame);
        s.x1    = COORD_W'(40 * frame + 199);
        s.y0    = COORD_W'(50);
        s.y1    = COORD_W'(249);
        s.color = {CH_FULL, CH_NONE, CH_NONE};
      end
      1: begin
        s.x0    = COORD_W'(300);
        s.x1    = COORD_W'(459);
        s.y0    = COORD_W'(200 + 10 * frame);
        s.y1    = COORD_W'(349 + 10 * frame);
        s.color = {CH_NONE, CH_FULL, CH_NONE};
      end
      2: begin
        s.kind  = SK_DIAG;
        s.x0    = COORD_W'(20);
        s.x1    = COORD_W'(120 + 20 * frame);
        s.y0    = COORD_W'(20);
        s.y1    = COORD_W'(20);
        s.color = {CH_FULL, CH_FULL, CH_FULL};
      end
      3: begin
        s.x0    = COORD_W'(0);
        s.x1    = COORD_W'(639);
        s.y0    = COORD_W'(470);
        s.y1    = COORD_W'(479);
        s.color = {CH_NONE, CH_NONE, CH_W'(8 + frame)};
      end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fp_shape_hit.sv
module fp_shape_hit
  import fp_pkg::*;
#(
  parameter shape_t SHAPE = '0
) (
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  output logic               hit
);

  logic in_cols;
  assign in_cols = (pix_x >= SHAPE.x0) && (pix_x <= SHAPE.x1);

  generate
    if (SHAPE.kind == SK_DIAG) begin : g_diag
      logic [COORD_W-1:0] dx;
      logic [COORD_W-1:0] dy;
      assign dx  = pix_x - SHAPE.x0;
      assign dy  = pix_y - SHAPE.y0;
      assign hit = in_cols && (pix_y >= SHAPE.y0) && (dx == dy);
    end else begin : g_rect
      assign hit = in_cols && (pix_y >= SHAPE.y0) && (pix_y <= SHAPE.y1);
    end
  endgenerate

endmodule

// File: rtl/fp_frame_sel.sv
module fp_frame_sel
  import fp_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int SEL_W     = $clog2(NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   sel_in,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  output logic [SEL_W-1:0]   frame_now
);

  logic [SEL_W-1:0] sync1_q;
  logic [SEL_W-1:0] sync2_q;
  logic [SEL_W-1:0] active_q;
  logic             at_start;

  assign at_start  = (pix_x == '0) && (pix_y == '0);
  assign frame_now = at_start ? sync2_q : active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      active_q <= '0;
    end else begin
      sync1_q  <= sel_in;
      sync2_q  <= sync1_q;
      active_q <= frame_now;
    end
  end

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !at_start |-> frame_now == active_q) else $error("frame changed mid-frame"); // R8

  AST_FRAME_KEEP: assert property (@(posedge clk) disable iff (rst)
    !at_start |=> $stable(active_q)) else $error("active frame moved"); // R8

endmodule

// File: rtl/fp_color_pick.sv
module fp_color_pick
  import fp_pkg::*;
#(
  parameter int NUM_SHAPES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  blank,
  input  logic [NUM_SHAPES-1:0] hits,
  input  logic [COLOR_W-1:0]    colors [NUM_SHAPES],
  output logic [COLOR_W-1:0]    rgb_q
);

  logic [NUM_SHAPES-1:0] grant;
  logic [COLOR_W-1:0]    picked;

  // Lowest set bit of the hit vector wins.
  assign grant = hits & (~hits + NUM_SHAPES'(1));

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_SHAPES; i++) begin
      if (grant[i]) picked = picked | colors[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rgb_q <= '0;
    else if (blank) rgb_q <= '0;
    else            rgb_q <= picked;
  end

  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((hits != '0) -> (grant != '0))) else $error("bad grant"); // R6

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    hits[0] |-> grant[0]) else $error("index 0 lost"); // R6

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    blank |=> rgb_q == '0) else $error("colour during blank"); // R2

  AST_BG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hits == '0) |=> rgb_q == '0) else $error("background not black"); // R7

endmodule

// File: rtl/frame_painter.sv
module frame_painter
  import fp_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int NUM_SHAPES = 4,
  localparam int SEL_W     = $clog2(NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic               blank,
  input  logic [SEL_W-1:0]   frame_sel,
  output logic [CH_W-1:0]    red,
  output logic [CH_W-1:0]    green,
  output logic [CH_W-1:0]    blue
);

  logic [SEL_W-1:0]      frame_now;
  logic [NUM_SHAPES-1:0] hit_all   [NUM_FRAMES];
  logic [COLOR_W-1:0]    color_all [NUM_FRAMES][NUM_SHAPES];
  logic [NUM_SHAPES-1:0] hit_sel;
  logic [COLOR_W-1:0]    color_sel [NUM_SHAPES];
  logic [COLOR_W-1:0]    rgb_q;

  fp_frame_sel #(.NUM_FRAMES(NUM_FRAMES)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .sel_in    (frame_sel),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .frame_now (frame_now)
  );

  generate
    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
      for (genvar i = 0; i < NUM_SHAPES; i++) begin : g_shape
        localparam shape_t SHP = shape_of(f, i);
        fp_shape_hit #(.SHAPE(SHP)) u_hit (
          .pix_x (pix_x),
          .pix_y (pix_y),
          .hit   (hit_all[f][i])
        );
        assign color_all[f][i] = SHP.color;
      end
    end
  endgenerate

  // Frame multiplexer: route the active frame's hits and colours.
  assign hit_sel = hit_all[frame_now];
  always_comb begin
    for (int i = 0; i < NUM_SHAPES; i++) color_sel[i] = color_all[frame_now][i];
  end

  fp_color_pick #(.NUM_SHAPES(NUM_SHAPES)) u_pick (
    .clk    (clk),
    .rst    (rst),
    .blank  (blank),
    .hits   (hit_sel),
    .colors (color_sel),
    .rgb_q  (rgb_q)
  );

  assign red   = rgb_q[3*CH_W-1:2*CH_W];
  assign green = rgb_q[2*CH_W-1:CH_W];
  assign blue  = rgb_q[CH_W-1:0];

  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (red == '0) && (green == '0) && (blue == '0)) else $error("colour after reset"); // R1

endmodule

// File: tb/frame_painter_tb.sv
module frame_painter_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] pix_x = '0;
  logic [9:0] pix_y = '0;
  logic       blank = 1'b0;
  logic [2:0] frame_sel = '0;
  logic [3:0] red, green, blue;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  frame_painter dut_i (
    .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .blank(blank),
    .frame_sel(frame_sel), .red(red), .green(green), .blue(blue)
  );

  typedef struct packed {
    logic [9:0]  x;
    logic [9:0]  y;
    logic        b;
    logic [11:0] exp;
    logic [7:0]  req;
  } vec_t;

  // Frame 0 vectors, expected colours from the shape list.
  localparam vec_t VEC [14] = '{
    '{10'd0,   10'd50,  1'b0, 12'hF00, 8'd4},  // R4 left/top corner
    '{10'd199, 10'd249, 1'b0, 12'hF00, 8'd4},  // R4 far corner
    '{10'd200, 10'd249, 1'b0, 12'h000, 8'd7},  // R7 just outside
    '{10'd0,   10'd49,  1'b0, 12'h000, 8'd7},  // R7 above
    '{10'd30,  10'd30,  1'b0, 12'hFFF, 8'd5},  // R5 on diagonal
    '{10'd30,  10'd31,  1'b0, 12'h000, 8'd5},  // R5 off diagonal
    '{10'd19,  10'd19,  1'b0, 12'h000, 8'd5},  // R5 before start
    '{10'd120, 10'd120, 1'b0, 12'hF00, 8'd6},  // R6 diag under rect
    '{10'd300, 10'd200, 1'b0, 12'h0F0, 8'd4},  // R4 green corner
    '{10'd459, 10'd349, 1'b0, 12'h0F0, 8'd4},  // R4 green far corner
    '{10'd460, 10'd349, 1'b0, 12'h000, 8'd4},  // R4 one past x1
    '{10'd639, 10'd479, 1'b0, 12'h008, 8'd9},  // R9 bottom bar
    '{10'd50,  10'd50,  1'b1, 12'h000, 8'd2},  // R2 blank on overlap
    '{10'd50,  10'd50,  1'b0, 12'hF00, 8'd6}   // R6 overlap, index 0 wins
  };

  function automatic logic [11:0] model(int f, int x, int y, bit b);
    if (b) return 12'h000;
    if (x >= 40*f && x <= 40*f+199 && y >= 50 && y <= 249) return 12'hF00;
    if (x >= 300 && x <= 459 && y >= 200+10*f && y <= 349+10*f) return 12'h0F0;
    if (x >= 20 && x <= 120+20*f && (x-20) == (y-20)) return 12'hFFF;
    if (y >= 470 && y <= 479) return {8'h00, 4'(8+f)};
    return 12'h000;
  endfunction

  task automatic check(string tag, logic [11:0] exp);
    total++;
    if ({red, green, blue} !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, {red, green, blue}, exp);
    end
  endtask

  // Present a pixel, then sample one edge later (R3 latency).
  task automatic px(int x, int y, bit b);
    @(negedge clk);
    pix_x = 10'(x); pix_y = 10'(y); blank = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset colour", 12'h000);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      px(int'(VEC[i].x), int'(VEC[i].y), VEC[i].b);
      check($sformatf("R%0d table row %0d", VEC[i].req, i), VEC[i].exp);
    end

    // R3: output follows the previous cycle's pixel.
    @(negedge clk); pix_x = 10'd30; pix_y = 10'd30; blank = 1'b0;
    #1 check("R3 before edge still old", 12'hF00);
    @(posedge clk); #1 check("R3 after edge", 12'hFFF);

    // R8: code held, no frame start -> still frame 0.
    @(negedge clk); frame_sel = 3'd3;
    repeat (4) begin
      px(310, 240, 0);
      check("R8 no change mid-frame", model(0, 310, 240, 0));
    end
    px(0, 0, 0);
    check("R8 frame start pixel", model(3, 0, 0, 0));
    px(310, 240, 0);
    check("R8 adopted frame 3", 12'hF00);

    // R8: code changes right at frame start; adoption waits two edges.
    @(negedge clk); frame_sel = 3'd5; pix_x = '0; pix_y = '0;
    @(posedge clk);
    px(0, 0, 0);
    px(420, 240, 0);
    check("R8 too early, still frame 3", 12'h0F0);
    px(0, 0, 0);
    px(420, 240, 0);
    check("R8 adopted frame 5", model(5, 420, 240, 0));
    px(380, 100, 0);
    check("R9 frame 5 red", model(5, 380, 100, 0));

    // R5/R9: diagonal endpoint in frame 7.
    @(negedge clk); frame_sel = 3'd7;
    repeat (2) @(posedge clk);
    px(0, 0, 0);
    px(260, 260, 0);
    check("R5 diagonal end frame 7", 12'hFFF);
    px(261, 261, 0);
    check("R5 past diagonal end", 12'h000);
    px(100, 475, 0);
    check("R9 bar blue frame 7", 12'h00F);

    // R1: mid-run reset, frame returns to 0.
    @(negedge clk); frame_sel = 3'd5; rst = 1'b1; pix_x = 10'd50; pix_y = 10'd50;
    @(posedge clk); #1 check("R1 reset mid-run", 12'h000);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(posedge clk);
    px(310, 240, 0);
    check("R1 frame 0 after reset", model(0, 310, 240, 0));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule